// File: doc/BRIEF.md
# Status-Qualified Two-Digit BCD Output Port

This block sits on the bus of an 8-bit microprocessor that does not report the kind of machine cycle on dedicated pins. Instead, each machine cycle opens with a SYNC pulse, and while that pulse is high the data bus carries a status byte describing the cycle. The port records that status byte on the clock edge where SYNC is high and holds it for the rest of the cycle. From the held byte it works out whether the cycle is an I/O output cycle.

When the active-low write strobe returns high, the port loads the byte on the data bus into an 8-bit register. It does this only if the held status marks an output cycle and the low address byte selects this port. Address selection is set by parameter. Full decoding compares the whole low address byte with a port number. Partial decoding tests one low address bit against a chosen level.

The register holds two packed BCD digits for display logic further down the chip: the upper nibble is the tens digit and the lower nibble is the units digit.

Top module: `bcd_out_port`

## Requirements
- R1: A synchronous active-high reset clears the port register to 0x00 and the held status to 0x00, which does not mark an output cycle.
- R2: On every rising clock edge where `sync_i` is high, the held status takes the value of `data_i`; while `sync_i` is low it keeps its value.
- R3: The held status marks an output cycle exactly when its bit 4 is 1 and its bit 1 is 0. Bit 4 is the output-cycle flag and bit 1 is an active-low write-output flag.
- R4: The port register loads `data_i` on the first rising clock edge at which `wr_n_i` is sampled high after having been sampled low on the previous edge. The load needs the held status to mark an output cycle and the address to select the port at that same edge. The new value appears at the outputs right after that edge.
- R5: A completed write strobe whose address does not select the port leaves the port register unchanged.
- R6: A completed write strobe during a cycle whose held status is not an output cycle leaves the port register unchanged. This includes a status whose bit 4 is 0 and one whose bit 1 is 1.
- R7: The port register keeps its value on every edge that does not complete a qualifying write, including the whole time the strobe is held low.
- R8: `tens_o` equals bits 7:4 of the port register and `units_o` equals bits 3:0.
- R9: With `FULL_DECODE`=1 the port is selected when `addr_i` equals `PORT_ADDR`. With `FULL_DECODE`=0 it is selected when `addr_i[SEL_BIT]` equals `SEL_LEVEL`, whatever the other address bits are.
- R10: A new SYNC replaces the held status, so an output status from an earlier cycle does not qualify a write in a later cycle whose own status is not an output cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | High at the start of each machine cycle, while the status byte is on the bus |
| data_i | input | 8 | Shared bus: status byte during SYNC, write data later in the cycle |
| addr_i | input | 8 | Low address byte of the current cycle |
| wr_n_i | input | 1 | Active-low write strobe |
| port_o | output | 8 | Port register, two packed BCD digits |
| tens_o | output | 4 | Tens digit (upper nibble) |
| units_o | output | 4 | Units digit (lower nibble) |

## Verification
The hardest case to reach is a stale status. An output-cycle status is held from one cycle, and a later SYNC with a non-output status must cancel it before a write with a matching address arrives. The bench builds this case directly, by following an output cycle with a cycle whose status has bit 4 clear or bit 1 set. Random cycles, biased toward output status codes and the selected address, then cover the mix of mismatched and qualifying writes. A second instance in partial-decode mode sees the same stimulus, with addresses that differ from the port number but hit the tested bit.

// File: rtl/bcd_port_pkg.sv
package bcd_port_pkg;
  localparam int STAT_OUT_BIT = 4;  // output-cycle flag, active high
  localparam int STAT_WO_BIT  = 1;  // write-output flag, active low
  localparam logic [7:0] STAT_IDLE = 8'h00;

  function automatic logic is_out_cycle(input logic [7:0] st);
    return st[STAT_OUT_BIT] & ~st[STAT_WO_BIT];
  endfunction
endpackage

// File: rtl/cycle_status_cap.sv
module cycle_status_cap
  import bcd_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] stat_o,
  output logic              out_cyc_o
);
  logic [DATA_W-1:0] stat_q;

  always_ff @(posedge clk) begin
    if (rst)         stat_q <= DATA_W'(STAT_IDLE);
    else if (sync_i) stat_q <= bus_i;
  end

  assign stat_o    = stat_q;
  assign out_cyc_o = is_out_cycle(stat_q[7:0]);
endmodule

// File: rtl/port_addr_match.sv
module port_addr_match #(
  parameter int          ADDR_W      = 8,
  parameter bit          FULL_DECODE = 1'b1,
  parameter logic [7:0]  PORT_ADDR   = 8'h27,
  parameter int          SEL_BIT     = 3,
  parameter bit          SEL_LEVEL   = 1'b1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  generate
    if (FULL_DECODE) begin : g_full
      assign hit_o = (addr_i == ADDR_W'(PORT_ADDR));
    end else begin : g_bit
      assign hit_o = (addr_i[SEL_BIT] == SEL_LEVEL);
    end
  endgenerate
endmodule

// File: rtl/strobe_port_reg.sv
module strobe_port_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_n_i,
  input  logic              qual_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] val_o
);
  logic              wr_n_q;
  logic              wr_done;
  logic [DATA_W-1:0] val_q;

  assign wr_done = wr_n_i & ~wr_n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_n_q <= 1'b1;
      val_q  <= '0;
    end else begin
      wr_n_q <= wr_n_i;
      if (wr_done && qual_i) val_q <= bus_i;
    end
  end

  assign val_o = val_q;
endmodule

// File: rtl/bcd_out_port.sv
module bcd_out_port #(
  parameter int         DATA_W      = 8,
  parameter int         ADDR_W      = 8,
  parameter bit         FULL_DECODE = 1'b1,
  parameter logic [7:0] PORT_ADDR   = 8'h27,
  parameter int         SEL_BIT     = 3,
  parameter bit         SEL_LEVEL   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_n_i,
  output logic [DATA_W-1:0] port_o,
  output logic [3:0]        tens_o,
  output logic [3:0]        units_o
);
  localparam int NIB = DATA_W / 2;

  logic [DATA_W-1:0] stat_q;
  logic              out_cyc;
  logic              addr_hit;

  cycle_status_cap #(.DATA_W(DATA_W)) u_stat (
    .clk(clk), .rst(rst), .sync_i(sync_i), .bus_i(data_i),
    .stat_o(stat_q), .out_cyc_o(out_cyc)
  );

  port_addr_match #(
    .ADDR_W(ADDR_W), .FULL_DECODE(FULL_DECODE), .PORT_ADDR(PORT_ADDR),
    .SEL_BIT(SEL_BIT), .SEL_LEVEL(SEL_LEVEL)
  ) u_dec (
    .addr_i(addr_i), .hit_o(addr_hit)
  );

  strobe_port_reg #(.DATA_W(DATA_W)) u_reg (
    .clk(clk), .rst(rst), .wr_n_i(wr_n_i), .qual_i(out_cyc & addr_hit),
    .bus_i(data_i), .val_o(port_o)
  );

  assign tens_o  = port_o[DATA_W-1 -: NIB];
  assign units_o = port_o[NIB-1:0];
endmodule

// File: rtl/bcd_out_port_chk.sv
module bcd_out_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              sync_i,
  input logic              wr_n_i,
  input logic [DATA_W-1:0] data_i,
  input logic [DATA_W-1:0] port_o,
  input logic [DATA_W-1:0] stat_q,
  input logic              out_cyc,
  input logic              addr_hit
);
  logic wr_prev;
  logic wr_end;

  always_ff @(posedge clk) begin
    if (rst) wr_prev <= 1'b1;
    else     wr_prev <= wr_n_i;
  end
  assign wr_end = wr_n_i & ~wr_prev;

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (port_o == '0));

  p_status_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !sync_i |=> $stable(stat_q));

  p_status_take_r2: assert property (@(posedge clk) disable iff (rst)
    sync_i |=> (stat_q == $past(data_i)));

  p_load_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_end && out_cyc && addr_hit) |=> (port_o == $past(data_i)));

  p_no_load_miss_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_end && !addr_hit) |=> $stable(port_o));

  p_no_load_stat_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_end && !out_cyc) |=> $stable(port_o));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !wr_end |=> $stable(port_o));
endmodule

bind bcd_out_port bcd_out_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .sync_i(sync_i), .wr_n_i(wr_n_i), .data_i(data_i),
  .port_o(port_o), .stat_q(stat_q), .out_cyc(out_cyc), .addr_hit(addr_hit)
);

// File: tb/tb_bcd_out_port.sv
module tb_bcd_out_port;
  localparam logic [7:0] PADDR = 8'h27;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sync_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic [7:0] addr_i = 8'h00;
  logic       wr_n_i = 1'b1;
  logic [7:0] port_f, port_b;
  logic [3:0] tens_f, units_f, tens_b, units_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] exp_f = 8'h00;
  logic [7:0] exp_b = 8'h00;

  always #2.5 clk = ~clk;

  bcd_out_port #(.FULL_DECODE(1'b1), .PORT_ADDR(PADDR)) dut (
    .clk(clk), .rst(rst), .sync_i(sync_i), .data_i(data_i), .addr_i(addr_i),
    .wr_n_i(wr_n_i), .port_o(port_f), .tens_o(tens_f), .units_o(units_f)
  );

  bcd_out_port #(.FULL_DECODE(1'b0), .SEL_BIT(3), .SEL_LEVEL(1'b1)) dut_bit (
    .clk(clk), .rst(rst), .sync_i(sync_i), .data_i(data_i), .addr_i(addr_i),
    .wr_n_i(wr_n_i), .port_o(port_b), .tens_o(tens_b), .units_o(units_b)
  );

  function automatic bit exp_out(input logic [7:0] st);
    return (st[4] == 1'b1) && (st[1] == 1'b0);
  endfunction
  function automatic bit hit_full(input logic [7:0] a);
    return a == PADDR;
  endfunction
  function automatic bit hit_bit(input logic [7:0] a);
    return a[3] == 1'b1;
  endfunction

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check8(tag, port_f, exp_f);
    check8({tag, " bit-mode R9"}, port_b, exp_b);
    check8("R8 tens", {4'h0, tens_f}, {4'h0, exp_f[7:4]});
    check8("R8 units", {4'h0, units_f}, {4'h0, exp_f[3:0]});
  endtask

  // one bus cycle: status during SYNC, then optional write strobe
  task automatic bus_cycle(input logic [7:0] st, input logic [7:0] a,
                           input logic [7:0] d, input bit wr, input string tag);
    @(negedge clk); sync_i = 1'b1; data_i = st; addr_i = 8'($urandom);
    @(negedge clk); sync_i = 1'b0; data_i = d; addr_i = a; wr_n_i = wr ? 1'b0 : 1'b1;
    @(negedge clk);
    @(negedge clk);
    check8("R7 strobe low", port_f, exp_f);
    wr_n_i = 1'b1;
    @(negedge clk);
    if (wr && exp_out(st) && hit_full(a)) exp_f = d;
    if (wr && exp_out(st) && hit_bit(a))  exp_b = d;
    check_all(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    if (!done) $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rst = 1'b0;

    bus_cycle(8'h10, PADDR, 8'h59, 1, "R4 load full");
    check8("R8 tens 5", {4'h0, tens_f}, 8'h05);
    check8("R8 units 9", {4'h0, units_f}, 8'h09);
    bus_cycle(8'h10, 8'h20, 8'h13, 1, "R5 addr miss");
    bus_cycle(8'h00, PADDR, 8'h42, 1, "R6 bit4 clear");
    bus_cycle(8'h12, PADDR, 8'h42, 1, "R6 bit1 set");
    bus_cycle(8'h10, PADDR, 8'h77, 0, "R7 no strobe");
    bus_cycle(8'h10, 8'h08, 8'h31, 1, "R9 bit hit only");
    bus_cycle(8'h10, PADDR, 8'h86, 1, "R4 reload");
    // R10: stale output status must not qualify a later non-output cycle
    bus_cycle(8'h10, 8'h00, 8'h11, 0, "R10 setup");
    bus_cycle(8'h02, PADDR, 8'h95, 1, "R10 stale status");
    // R2: status held across a long gap with SYNC low
    bus_cycle(8'h1C, 8'h01, 8'h00, 0, "R2 setup");
    repeat (5) @(negedge clk);
    bus_cycle(8'h1C, PADDR, 8'h64, 1, "R2 held status");

    // R3 exhaustively over status bits 4 and 1
    for (int k = 0; k < 4; k++) begin
      logic [7:0] st;
      st = 8'h00;
      st[4] = k[1];
      st[1] = k[0];
      bus_cycle(st, PADDR, 8'(8'h20 + k), 1, "R3 status decode");
    end

    for (int i = 0; i < 300; i++) begin
      logic [7:0] st, a, d;
      st = 8'($urandom);
      if ($urandom_range(1, 0) == 1) begin st[4] = 1'b1; st[1] = 1'b0; end
      a = ($urandom_range(2, 0) == 0) ? 8'($urandom) : PADDR;
      d = {4'($urandom_range(9, 0)), 4'($urandom_range(9, 0))};
      bus_cycle(st, a, d, $urandom_range(4, 0) != 0, "R4 random");
    end

    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    exp_f = 8'h00; exp_b = 8'h00;
    check_all("R1 re-reset");
    bus_cycle(8'h00, PADDR, 8'h55, 1, "R1 status cleared");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule